// File: doc/BRIEF.md
# Microsecond Timer with Dual Edge Capture

This block keeps a 12-bit counter that advances once per microsecond and wraps from its top value back to zero. A clock-enable divider derives the microsecond step from the core clock. Two single-cycle strobes come from the counter: a fast one each time the count reaches a multiple of 128 and a slow one each time it reaches a multiple of 1024. Interrupt logic elsewhere uses them as periodic timebases.

Two capture channels each watch one asynchronous input. After a two-flop synchronizer, a rising transition stores an 8-bit window of the count in that channel's rising-time register, and a falling transition stores it in the falling-time register. A shared prescale field picks which window is stored, so firmware trades resolution for range. Each event sets a sticky status flag. Each channel raises its own interrupt request when a flag is set and the matching enable bit is on.

A small register port gives access to the count, the four captured times, the control word and the status flags. Reading the low count byte freezes the upper count bits, so a 12-bit value can be read as two bytes without tearing. Reset is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `usec_capture_timer`

## Requirements
- R1: The count rises by exactly one every TICK_DIV clock cycles and wraps from 4095 to 0.
- R2: `tap_fast` is high for one clock cycle, in the cycle where the count has just become a multiple of 128.
- R3: `tap_slow` is high for one clock cycle, in the cycle where the count has just become a multiple of 1024, and always together with `tap_fast`.
- R4: Address 0 reads count bits 7:0 combinationally. A read strobe at address 0 freezes count bits 11:8. Address 1 returns that frozen nibble in bits 3:0 with bits 7:4 zero, and stays unchanged until the next strobed read at address 0.
- R5: A capture input change present at clock edge n is stored at edge n+2, using the count value held between edges n+1 and n+2. A rising change goes to the rising register and a falling change to the falling register. The other register of that channel is left unchanged. Channel A rise/fall are at addresses 2/3 and channel B rise/fall at 4/5.
- R6: Prescale (control bits 2:0) code k for k = 0..4 stores count bits k+7:k. Codes 5, 6 and 7 act like code 4.
- R7: The status register at address 7 holds sticky event flags: bit 0 A rise, bit 1 A fall, bit 2 B rise, bit 3 B fall. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R8: `irq[0]` is (A-rise flag AND control bit 3) OR (A-fall flag AND control bit 4). `irq[1]` is the same for channel B using control bits 5 and 6. The control register is at address 6 and can be read back.
- R9: After reset the control, status and capture registers read zero and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 2 | Capture inputs, bit 0 channel A, bit 1 channel B |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only its side effect at address 0 matters |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tap_fast | output | 1 | Pulse at each multiple of 128 counts |
| tap_slow | output | 1 | Pulse at each multiple of 1024 counts |
| irq | output | 2 | Interrupt request per channel |

## Verification
The bench sets TICK_DIV to 2, so the count steps every other clock. A full 4096-count period then fits in about 8200 cycles, which lets the bench watch the wrap, several slow-tap periods and the eight fast taps between them in a short run. The other parameters keep their defaults: 12-bit count, 8-bit captures and five distinct prescale windows. Every window code, including the saturating ones, is therefore reachable and has a distinct expected value at the ports.

// File: rtl/utmr_pkg.sv
`timescale 1ns/1ps
package utmr_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int PSC_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CNT_LO = 3'd0,
    RA_CNT_HI = 3'd1,
    RA_A_RISE = 3'd2,
    RA_A_FALL = 3'd3,
    RA_B_RISE = 3'd4,
    RA_B_FALL = 3'd5,
    RA_CTRL   = 3'd6,
    RA_STAT   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/utmr_base.sv
`timescale 1ns/1ps
// Microsecond divider, free-running counter and periodic tap strobes.
module utmr_base #(
  parameter int CNT_W    = 12,
  parameter int TICK_DIV = 48,
  parameter int TAP_LO   = 7,
  parameter int TAP_HI   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tap_lo_o,
  output logic             tap_hi_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             tap_lo_q, tap_lo_d, tap_hi_q, tap_hi_d;

  generate
    if (TICK_DIV > 1) begin : g_div
      always_comb begin
        tick  = (div_q == DIV_LAST);
        div_d = tick ? '0 : div_q + DIV_W'(1);
      end
    end else begin : g_nodiv
      always_comb begin
        tick  = 1'b1;
        div_d = '0;
      end
    end
  endgenerate

  always_comb begin
    cnt_inc  = cnt_q + CNT_W'(1);
    cnt_d    = tick ? cnt_inc : cnt_q;
    tap_lo_d = tick && (cnt_inc[TAP_LO-1:0] == '0);
    tap_hi_d = tick && (cnt_inc[TAP_HI-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      cnt_q    <= '0;
      tap_lo_q <= 1'b0;
      tap_hi_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      tap_lo_q <= tap_lo_d;
      tap_hi_q <= tap_hi_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign tap_lo_o = tap_lo_q;
  assign tap_hi_o = tap_hi_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  p_tap_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_lo_q |-> (cnt_q[TAP_LO-1:0] == '0));
  p_tap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_lo_q |=> !tap_lo_q);
  p_tap_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tap_hi_q |-> tap_lo_q);
endmodule

// File: rtl/utmr_edge_chan.sv
`timescale 1ns/1ps
// One capture channel: synchronizer, edge detector, rise/fall time registers.
module utmr_edge_chan #(
  parameter int CAP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CAP_W-1:0] slice_i,
  output logic             rise_evt_o,
  output logic             fall_evt_o,
  output logic [CAP_W-1:0] rise_val_o,
  output logic [CAP_W-1:0] fall_val_o
);
  logic [SYNC_STAGES:0] sh_q, sh_d;
  logic                 lvl, prv, rise, fall;
  logic [CAP_W-1:0]     rise_q, rise_d, fall_q, fall_d;

  always_comb begin
    sh_d   = {sh_q[SYNC_STAGES-1:0], pin_i};
    lvl    = sh_q[SYNC_STAGES-1];
    prv    = sh_q[SYNC_STAGES];
    rise   = lvl & ~prv;
    fall   = ~lvl & prv;
    rise_d = rise ? slice_i : rise_q;
    fall_d = fall ? slice_i : fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      sh_q   <= sh_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise_evt_o = rise;
  assign fall_evt_o = fall;
  assign rise_val_o = rise_q;
  assign fall_val_o = fall_q;

  p_rise_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (rise_q == $past(slice_i)));
  p_fall_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (fall_q == $past(slice_i)));
  p_rise_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(rise_q));
  p_fall_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(fall_q));
endmodule

// File: rtl/utmr_regs.sv
`timescale 1ns/1ps
// Register port: count read with nibble freeze, control, W1C status, window select, irq.
module utmr_regs
  import utmr_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int CAP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [NUM_CH-1:0]             rise_evt_i,
  input  logic [NUM_CH-1:0]             fall_evt_i,
  input  logic [NUM_CH-1:0][CAP_W-1:0]  rise_val_i,
  input  logic [NUM_CH-1:0][CAP_W-1:0]  fall_val_i,
  output logic [CAP_W-1:0]              slice_o,
  output logic [NUM_CH-1:0]             irq_o
);
  localparam int HI_W      = CNT_W - DATA_W;
  localparam int MAX_SHIFT = CNT_W - CAP_W;
  localparam int EVT_W     = 2 * NUM_CH;
  localparam int CTRL_W    = PSC_W + EVT_W;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [EVT_W-1:0]  stat_q, stat_d, ev, clr, en;
  logic [PSC_W-1:0]  psc;
  logic              hi_en, ctrl_en;
  reg_addr_e         ra;
  logic [CAP_W-1:0]  cand [MAX_SHIFT+1];

  assign ra  = reg_addr_e'(addr_i);
  assign psc = ctrl_q[PSC_W-1:0];
  assign en  = ctrl_q[CTRL_W-1:PSC_W];

  generate
    for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_win
      assign cand[g] = cnt_i[g +: CAP_W];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ev[2*c]     = rise_evt_i[c];
      assign ev[2*c + 1] = fall_evt_i[c];
      assign irq_o[c]    = |(stat_q[2*c +: 2] & en[2*c +: 2]);
    end
  endgenerate

  always_comb begin
    slice_o = cand[MAX_SHIFT];
    for (int k = 0; k < MAX_SHIFT; k++) begin
      if (int'(psc) == k) slice_o = cand[k];
    end
  end

  always_comb begin
    hi_en   = rd_i && (ra == RA_CNT_LO);
    hi_d    = hi_en ? cnt_i[CNT_W-1:DATA_W] : hi_q;
    ctrl_en = wr_i && (ra == RA_CTRL);
    ctrl_d  = ctrl_en ? wdata_i[CTRL_W-1:0] : ctrl_q;
    clr     = (wr_i && (ra == RA_STAT)) ? wdata_i[EVT_W-1:0] : '0;
    stat_d  = (stat_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      hi_q   <= hi_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (ra)
      RA_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
      RA_CNT_HI: rdata_o = DATA_W'(hi_q);
      RA_A_RISE: rdata_o = DATA_W'(rise_val_i[0]);
      RA_A_FALL: rdata_o = DATA_W'(fall_val_i[0]);
      RA_B_RISE: rdata_o = DATA_W'(rise_val_i[1]);
      RA_B_FALL: rdata_o = DATA_W'(fall_val_i[1]);
      RA_CTRL:   rdata_o = DATA_W'(ctrl_q);
      default:   rdata_o = DATA_W'(stat_q);
    endcase
  end

  p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == RA_CNT_HI) |-> (rdata_o[DATA_W-1:HI_W] == '0));
  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> $stable(hi_q));
  p_win_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(psc) >= MAX_SHIFT) |-> (slice_o == cnt_i[CNT_W-1 -: CAP_W]));
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> (stat_q != '0));
endmodule

// File: rtl/usec_capture_timer.sv
`timescale 1ns/1ps
// Top: reset release synchronizer, counter, capture channels, register port.
module usec_capture_timer
  import utmr_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int CAP_W        = 8,
  parameter int TICK_DIV     = 48,
  parameter int TAP_FAST_BIT = 7,
  parameter int TAP_SLOW_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tap_fast,
  output logic              tap_slow,
  output logic [NUM_CH-1:0] irq
);
  logic [1:0]                   rs_q;
  logic                         rst_int_n;
  logic [CNT_W-1:0]             cnt;
  logic [CAP_W-1:0]             slice;
  logic [NUM_CH-1:0]            rise_evt, fall_evt;
  logic [NUM_CH-1:0][CAP_W-1:0] rise_val, fall_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  utmr_base #(
    .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .TAP_LO(TAP_FAST_BIT), .TAP_HI(TAP_SLOW_BIT)
  ) u_base (
    .clk(clk), .rst_n(rst_int_n), .cnt_o(cnt), .tap_lo_o(tap_fast), .tap_hi_o(tap_slow)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
      utmr_edge_chan #(.CAP_W(CAP_W), .SYNC_STAGES(2)) u_chan (
        .clk(clk), .rst_n(rst_int_n), .pin_i(cap_in[c]), .slice_i(slice),
        .rise_evt_o(rise_evt[c]), .fall_evt_o(fall_evt[c]),
        .rise_val_o(rise_val[c]), .fall_val_o(fall_val[c])
      );
    end
  endgenerate

  utmr_regs #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .cnt_i(cnt),
    .rise_evt_i(rise_evt), .fall_evt_i(fall_evt),
    .rise_val_i(rise_val), .fall_val_i(fall_val),
    .slice_o(slice), .irq_o(irq)
  );

  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (irq == '0));
endmodule

// File: tb/sim_usec_capture_timer.sv
`timescale 1ns/1ps
module sim_usec_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap_in = '0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tap_fast, tap_slow;
  logic [1:0] irq;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  usec_capture_timer #(.TICK_DIV(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tap_fast(tap_fast), .tap_slow(tap_slow), .irq(irq)
  );

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic strobe, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = strobe;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic read_count(output int c);
    logic [7:0] lo, hi;
    bus_read(3'd0, 1'b1, lo);
    bus_read(3'd1, 1'b0, hi);
    c = {20'd0, hi[3:0], lo};
  endtask

  // drive one capture input to a level and return the count the design samples
  task automatic drive_edge(input int ch, input logic lvl, output int full);
    logic [7:0] lo, hi;
    @(negedge clk); cap_in[ch] = lvl;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 3'd0; bus_rd = 1'b1; #1 lo = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
    @(negedge clk); bus_addr = 3'd1; #1 hi = bus_rdata;
    full = {20'd0, hi[3:0], lo};
  endtask

  function automatic int window(input int full, input int psc);
    int sh = (psc > 4) ? 4 : psc;
    return (full >> sh) & 8'hFF;
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 2; a < 8; a++) begin
      bus_read(a[2:0], 1'b0, v);
      chk($sformatf("R9 reg %0d after reset", a), v, 0);
    end
    chk("R9 irq after reset", irq, 0);
  endtask

  task automatic t_count_rate();
    int c1, c2;
    read_count(c1);
    repeat (18) @(posedge clk);
    read_count(c2);
    chk("R1 ten steps in twenty cycles", c2, (c1 + 10) & 12'hFFF);
  endtask

  task automatic t_wrap();
    int c1, c2;
    c1 = 0;
    for (int i = 0; i < 6000; i++) begin
      read_count(c1);
      if (c1 >= 4086) break;
    end
    repeat (18) @(posedge clk);
    read_count(c2);
    chk("R1 wrap past 4095", c2, (c1 + 10) & 12'hFFF);
  endtask

  task automatic t_hi_freeze();
    logic [7:0] lo, h1, h2;
    bus_read(3'd0, 1'b1, lo);
    bus_read(3'd1, 1'b0, h1);
    repeat (700) @(posedge clk);
    bus_read(3'd1, 1'b0, h2);
    chk("R4 frozen nibble holds", h2, h1);
    chk("R4 upper bits zero", h2[7:4], 0);
  endtask

  task automatic t_taps();
    int n;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tap_fast) begin seen = 1'b1; break; end
    end
    bus_addr = 3'd0; #1;
    chk("R2 fast tap seen", seen, 1);
    chk("R2 count multiple of 128", bus_rdata[6:0], 0);
    @(negedge clk);
    chk("R2 fast tap one cycle", tap_fast, 0);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tap_slow) begin seen = 1'b1; break; end
    end
    chk("R3 slow tap seen", seen, 1);
    chk("R3 slow with fast", tap_fast, 1);
    bus_addr = 3'd0; #1;
    chk("R3 count low byte zero", bus_rdata, 0);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tap_fast) n++;
      if (tap_slow) break;
    end
    chk("R3 eight fast taps per slow period", n, 8);
  endtask

  task automatic t_capture(input int ch, input int psc);
    int full_r, full_f;
    logic [7:0] v, rise_v;
    bus_write(3'd6, psc[7:0]);
    bus_write(3'd7, 8'h0F);
    drive_edge(ch, 1'b1, full_r);
    bus_read(3'(2 + 2*ch), 1'b0, rise_v);
    chk($sformatf("R5 R6 rise ch%0d psc%0d", ch, psc), rise_v, window(full_r, psc));
    bus_read(3'd7, 1'b0, v);
    chk($sformatf("R7 rise flag ch%0d", ch), v, 1 << (2*ch));
    repeat (37) @(posedge clk);
    drive_edge(ch, 1'b0, full_f);
    bus_read(3'(3 + 2*ch), 1'b0, v);
    chk($sformatf("R5 R6 fall ch%0d psc%0d", ch, psc), v, window(full_f, psc));
    bus_read(3'(2 + 2*ch), 1'b0, v);
    chk($sformatf("R5 rise kept ch%0d", ch), v, rise_v);
    bus_read(3'd7, 1'b0, v);
    chk($sformatf("R7 both flags ch%0d", ch), v, 3 << (2*ch));
  endtask

  task automatic t_irq();
    int f;
    logic [7:0] v;
    bus_write(3'd7, 8'h0F);
    bus_write(3'd6, 8'h00);
    drive_edge(0, 1'b1, f);
    @(negedge clk);
    chk("R8 flag without enable gives no irq", irq, 0);
    bus_write(3'd6, 8'h08);
    bus_read(3'd6, 1'b0, v);
    chk("R8 control readback", v, 8'h08);
    chk("R8 irq A on enable", irq, 2'b01);
    bus_write(3'd7, 8'h02);
    bus_read(3'd7, 1'b0, v);
    chk("R7 write of unset bit keeps flag", v, 8'h01);
    chk("R8 irq A still set", irq, 2'b01);
    bus_write(3'd7, 8'h01);
    bus_read(3'd7, 1'b0, v);
    chk("R7 write one clears", v, 8'h00);
    chk("R8 irq A cleared", irq, 2'b00);
    bus_write(3'd6, 8'h40);
    drive_edge(0, 1'b0, f);
    drive_edge(1, 1'b1, f);
    drive_edge(1, 1'b0, f);
    @(negedge clk);
    chk("R8 irq B from fall enable", irq, 2'b10);
    bus_write(3'd7, 8'h0F);
    @(negedge clk);
    chk("R8 irq B cleared", irq, 2'b00);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got 150000 cycles expected completion sooner");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_count_rate();
    t_hi_freeze();
    t_taps();
    t_wrap();
    t_capture(0, 0);
    t_capture(1, 2);
    t_capture(0, 4);
    t_capture(1, 7);
    t_capture(0, 5);
    t_irq();
    summary();
    $finish;
  end
endmodule